// File: doc/BRIEF.md
# Two-Wire Memory Slave with Selective Acknowledge

This block is the bus front end of a device that holds a byte store and a set of control registers behind a two-wire serial bus. It oversamples the bus clock and data lines with the system clock and finds START and STOP conditions. It takes in a device-address byte, then two word-address bytes, then data. For each received byte it decides whether to pull the data line low in the acknowledge slot. It writes accepted data to an external store through a parallel port. In read mode it shifts stored bytes out MSB first.

The acknowledge decision is selective, not blanket. The device-address byte is acknowledged only when its identifier and strap-select fields match. Data bytes of a write are refused while the write permit from the protection logic is low. Inside the register window only one data byte per write is taken. A separate write-cycle controller can raise a busy input, and while it is high the slave is deaf and never drives the bus.

Top module: `i2c_selack_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts the byte machine at any bit position, and the next byte is treated as a device-address byte. A STOP (SDA rising while SCL is high) releases SDA and returns the slave to idle.
- R2: The device-address byte is `{identifier[3:0], select[2:0], rw}`, sent MSB first. It is acknowledged (sda_oe_o high through the ninth SCL pulse) only when identifier equals DEV_ID (default 4'b1101) and select equals dev_sel_i. On a mismatch the slave gives no acknowledge and stays silent until the next START.
- R3: After an acknowledged write-address byte (rw = 0), the next two bytes are taken as the high and then the low word-address byte. Each is acknowledged, and together they set the store pointer.
- R4: While write_permit_i is high, each data byte in the array space (pointer below REG_BASE, default 16'hFFC0) is acknowledged and written. The write is a one-cycle st_we_o pulse with st_addr_o equal to the pointer and st_wdata_o equal to the byte. The pointer then increments, so consecutive bytes land at consecutive addresses.
- R5: While write_permit_i is low, every data byte is left unacknowledged and nothing is written. The address bytes are still acknowledged.
- R6: In the register window (pointer at or above REG_BASE), the first data byte of a write is acknowledged and written. The second and all later data bytes of the same write are neither acknowledged nor written.
- R7: After an acknowledged read-address byte (rw = 1), the slave sends the byte at the pointer MSB first. It drives SDA low for 0 bits, releases SDA for 1 bits and for the acknowledge slot, and changes its drive only while SCL is low.
- R8: After a read byte, the pointer increments. If the master acknowledged, the next byte comes from the new pointer. If the master did not acknowledge, the slave keeps SDA released until a STOP or START.
- R9: While busy_i is high, sda_oe_o is low, no byte is acknowledged or written, and the byte machine returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| busy_i | input | 1 | Internal write cycle in progress; bus ignored |
| write_permit_i | input | 1 | Write-enable latch state from protection logic |
| dev_sel_i | input | SEL_W | Strap value the select field must match |
| st_addr_o | output | ADDR_W | Store pointer for writes and reads |
| st_wdata_o | output | 8 | Write data to the store |
| st_we_o | output | 1 | One-cycle store write strobe |
| st_rdata_i | input | 8 | Store data at st_addr_o (combinational read) |

## Verification
The assertions assume that SCL stays low and high for several system clocks per phase, longer than the synchronizer depth plus one register. They also assume the master changes SDA only while SCL is low, except to form START or STOP. Under those conditions every rise of the drive enable falls in an SCL-low window. The bench's master tasks hold each SCL quarter-phase for eight system clocks and move SDA only mid-low-phase. The one deliberate break of a byte is a START inserted after four bits. busy_i and write_permit_i change only while the bus is idle between transactions.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned CNT_W    = 4;
   localparam int unsigned ACK_BIT  = 8;
   localparam int unsigned SLOT_END = 9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDATA,
      ST_RDATA,
      ST_WAIT
   } slv_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
      logic scl;
   } bus_evt_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
   import i2cs_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o
);

   initial begin
      assert (STAGES >= 1 && STAGES <= 4)
         else $error("i2cs_line_sync: STAGES must be 1..4");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_prev, sda_prev;
   logic              scl_s, sda_s;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
               sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   always_comb begin
      evt_o.scl   = scl_s;
      evt_o.sda   = sda_s;
      evt_o.rise  = scl_s & ~scl_prev;
      evt_o.fall  = ~scl_s & scl_prev;
      evt_o.start = scl_s & scl_prev & sda_prev & ~sda_s;
      evt_o.stop  = scl_s & scl_prev & ~sda_prev & sda_s;
   end

endmodule

// File: rtl/i2cs_ack_policy.sv
module i2cs_ack_policy
   import i2cs_pkg::*;
#(
   parameter int unsigned        ID_W         = 4,
   parameter int unsigned        SEL_W        = 3,
   parameter logic [ID_W-1:0]    DEV_ID       = 4'b1101,
   parameter bit                 REG_ONE_BYTE = 1'b1
) (
   input  slv_state_e              state_i,
   input  logic [ID_W+SEL_W-1:0]   id_sel_i,
   input  logic [SEL_W-1:0]        strap_i,
   input  logic                    permit_i,
   input  logic                    in_reg_i,
   input  logic                    reg_taken_i,
   output logic                    ack_o
);

   logic id_match;
   logic reg_block;

   assign id_match = (id_sel_i[ID_W+SEL_W-1:SEL_W] == DEV_ID) &&
                     (id_sel_i[SEL_W-1:0] == strap_i);

   generate
      if (REG_ONE_BYTE) begin : g_reg_single
         assign reg_block = in_reg_i & reg_taken_i;
      end else begin : g_reg_burst
         assign reg_block = 1'b0;
      end
   endgenerate

   always_comb begin
      case (state_i)
         ST_DEV:   ack_o = id_match;
         ST_AHI,
         ST_ALO:   ack_o = 1'b1;
         ST_WDATA: ack_o = permit_i & ~reg_block;
         default:  ack_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/i2c_selack_slave.sv
module i2c_selack_slave
   import i2cs_pkg::*;
#(
   parameter int unsigned        ID_W         = 4,
   parameter int unsigned        SEL_W        = 3,
   parameter logic [ID_W-1:0]    DEV_ID       = 4'b1101,
   parameter int unsigned        ADDR_W       = 16,
   parameter logic [ADDR_W-1:0]  REG_BASE     = 16'hFFC0,
   parameter int unsigned        SYNC_STAGES  = 2,
   parameter bit                 REG_ONE_BYTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              busy_i,
   input  logic              write_permit_i,
   input  logic [SEL_W-1:0]  dev_sel_i,
   output logic [ADDR_W-1:0] st_addr_o,
   output logic [7:0]        st_wdata_o,
   output logic              st_we_o,
   input  logic [7:0]        st_rdata_i
);

   localparam int unsigned FULL_W = 2 * BYTE_W;

   initial begin
      assert (ID_W + SEL_W == BYTE_W - 1)
         else $error("i2c_selack_slave: ID_W + SEL_W must be 7");
      assert (ADDR_W > BYTE_W && ADDR_W <= FULL_W)
         else $error("i2c_selack_slave: ADDR_W must be 9..16");
   end

   bus_evt_t            evt;
   slv_state_e          state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [BYTE_W-1:0]   rx_q;
   logic [BYTE_W-2:0]   tx_q;
   logic [BYTE_W-1:0]   addr_hi_q;
   logic [BYTE_W-1:0]   wdata_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic                oe_q;
   logic                acked_q;
   logic                reg_taken_q;
   logic                tx_load_q;
   logic                we_q;
   logic                ack_w;
   logic                in_reg;
   logic                receiving;
   logic [FULL_W-1:0]   full_addr;

   // Signals exposed for the bound checker.
   logic                scl_lvl;
   logic                stop_det;

   i2cs_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt_o (evt)
   );

   assign in_reg    = (ptr_q >= REG_BASE);
   assign receiving = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                      (state_q == ST_ALO) || (state_q == ST_WDATA);
   assign full_addr = {addr_hi_q, rx_q};
   assign scl_lvl   = evt.scl;
   assign stop_det  = evt.stop;

   i2cs_ack_policy #(
      .ID_W         (ID_W),
      .SEL_W        (SEL_W),
      .DEV_ID       (DEV_ID),
      .REG_ONE_BYTE (REG_ONE_BYTE)
   ) u_policy (
      .state_i     (state_q),
      .id_sel_i    (rx_q[BYTE_W-1:1]),
      .strap_i     (dev_sel_i),
      .permit_i    (write_permit_i),
      .in_reg_i    (in_reg),
      .reg_taken_i (reg_taken_q),
      .ack_o       (ack_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         rx_q        <= '0;
         tx_q        <= '0;
         addr_hi_q   <= '0;
         wdata_q     <= '0;
         ptr_q       <= '0;
         oe_q        <= 1'b0;
         acked_q     <= 1'b0;
         reg_taken_q <= 1'b0;
         tx_load_q   <= 1'b0;
         we_q        <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (busy_i) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            oe_q      <= 1'b0;
            tx_load_q <= 1'b0;
         end else if (evt.start) begin
            state_q   <= ST_DEV;
            cnt_q     <= '0;
            oe_q      <= 1'b0;
            tx_load_q <= 1'b0;
         end else if (evt.stop) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            oe_q      <= 1'b0;
            tx_load_q <= 1'b0;
         end else if (tx_load_q) begin
            // Store read data settles one cycle after the pointer moves.
            tx_q      <= st_rdata_i[BYTE_W-2:0];
            oe_q      <= ~st_rdata_i[BYTE_W-1];
            tx_load_q <= 1'b0;
         end else if (evt.rise) begin
            if (receiving) begin
               if (cnt_q < CNT_W'(ACK_BIT)) begin
                  rx_q  <= {rx_q[BYTE_W-2:0], evt.sda};
                  cnt_q <= cnt_q + CNT_W'(1);
               end else if (cnt_q == CNT_W'(ACK_BIT)) begin
                  cnt_q <= CNT_W'(SLOT_END);
               end
            end else if (state_q == ST_RDATA) begin
               if (cnt_q == CNT_W'(ACK_BIT)) begin
                  acked_q <= ~evt.sda;
                  cnt_q   <= CNT_W'(SLOT_END);
               end else if (cnt_q < CNT_W'(ACK_BIT)) begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         end else if (evt.fall) begin
            if (receiving) begin
               if (cnt_q == CNT_W'(ACK_BIT)) begin
                  // Ninth clock begins: decide acknowledge for this byte.
                  oe_q    <= ack_w;
                  acked_q <= ack_w;
                  if (state_q == ST_AHI) begin
                     addr_hi_q <= rx_q;
                  end
                  if (state_q == ST_WDATA && ack_w) begin
                     we_q        <= 1'b1;
                     wdata_q     <= rx_q;
                     reg_taken_q <= reg_taken_q | in_reg;
                  end
               end else if (cnt_q == CNT_W'(SLOT_END)) begin
                  oe_q  <= 1'b0;
                  cnt_q <= '0;
                  case (state_q)
                     ST_DEV: begin
                        if (!acked_q) begin
                           state_q <= ST_IDLE;
                        end else if (rx_q[0]) begin
                           state_q   <= ST_RDATA;
                           tx_load_q <= 1'b1;
                        end else begin
                           state_q <= ST_AHI;
                        end
                     end
                     ST_AHI: state_q <= ST_ALO;
                     ST_ALO: begin
                        ptr_q       <= full_addr[ADDR_W-1:0];
                        reg_taken_q <= 1'b0;
                        state_q     <= ST_WDATA;
                     end
                     default: begin
                        if (acked_q) begin
                           ptr_q <= ptr_q + ADDR_W'(1);
                        end
                     end
                  endcase
               end
            end else if (state_q == ST_RDATA) begin
               if (cnt_q == CNT_W'(SLOT_END)) begin
                  cnt_q <= '0;
                  oe_q  <= 1'b0;
                  ptr_q <= ptr_q + ADDR_W'(1);
                  if (acked_q) begin
                     tx_load_q <= 1'b1;
                  end else begin
                     state_q <= ST_WAIT;
                  end
               end else if (cnt_q == CNT_W'(ACK_BIT)) begin
                  oe_q <= 1'b0;
               end else if (cnt_q != '0) begin
                  oe_q <= ~tx_q[BYTE_W-2];
                  tx_q <= {tx_q[BYTE_W-3:0], 1'b0};
               end
            end
         end
      end
   end

   assign sda_oe_o   = oe_q;
   assign st_addr_o  = ptr_q;
   assign st_wdata_o = wdata_q;
   assign st_we_o    = we_q;

endmodule

// File: rtl/i2c_selack_checker.sv
module i2c_selack_checker #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_i,
   input logic              write_permit_i,
   input logic              sda_oe_o,
   input logic              st_we_o,
   input logic [ADDR_W-1:0] st_addr_o,
   input logic              scl_lvl,
   input logic              stop_det
);

   // R9: a busy cycle leaves the line released on the next one.
   a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_i) |-> !sda_oe_o);

   // R5: a store write only follows a cycle with the permit high.
   a_r5_write_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
      st_we_o |-> $past(write_permit_i));

   // R4: the write strobe is a single-cycle pulse.
   a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      st_we_o |=> !st_we_o);

   // R4: the pointer is steady while a write is issued.
   a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      st_we_o |-> $stable(st_addr_o));

   // R1: a STOP releases the line.
   a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);

   // R7: the slave starts pulling SDA only while SCL is low.
   a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_lvl);

endmodule

bind i2c_selack_slave i2c_selack_checker #(
   .ADDR_W (ADDR_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy_i         (busy_i),
   .write_permit_i (write_permit_i),
   .sda_oe_o       (sda_oe_o),
   .st_we_o        (st_we_o),
   .st_addr_o      (st_addr_o),
   .scl_lvl        (scl_lvl),
   .stop_det       (stop_det)
);

// File: tb/tb_i2c_selack_slave.sv
`timescale 1ns/1ps
module tb_i2c_selack_slave;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_line;
   logic        busy = 1'b0;
   logic        permit = 1'b1;
   logic [2:0]  sel = 3'b010;
   logic        sda_oe;
   logic [15:0] st_addr;
   logic [7:0]  st_wdata;
   logic        st_we;
   logic [7:0]  st_rdata;
   logic [7:0]  mem [256];

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;
   assign st_rdata = mem[st_addr[7:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      end else if (st_we) begin
         mem[st_addr[7:0]] <= st_wdata;
      end
   end

   i2c_selack_slave dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .scl_i          (scl),
      .sda_i          (sda_line),
      .sda_oe_o       (sda_oe),
      .busy_i         (busy),
      .write_permit_i (permit),
      .dev_sel_i      (sel),
      .st_addr_o      (st_addr),
      .st_wdata_o     (st_wdata),
      .st_we_o        (st_we),
      .st_rdata_i     (st_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (8) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl = 1'b1;   wq();
      sda_m = 1'b0; wq();
      scl = 1'b0;   wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl = 1'b1;   wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq();
      scl = 1'b1; wq();
      ack = ~sda_line;
      wq();
      scl = 1'b0; wq();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         wq();
         scl = 1'b1; wq();
         b = {b[6:0], sda_line};
         wq();
         scl = 1'b0;
      end
      wq();
      sda_m = give_ack ? 1'b0 : 1'b1; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0;
      repeat (2) @(negedge clk);
      sda_m = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 reset sda_oe", sda_oe, 0);
      check("R1 reset st_we", st_we, 0);
   endtask

   task automatic t_mismatch();
      logic a;
      bus_start();
      send_byte(8'hE4, a); check("R2 wrong identifier nack", a, 0);
      send_byte(8'h00, a); check("R2 silent after mismatch", a, 0);
      bus_stop();
      bus_start();
      send_byte(8'hD6, a); check("R2 wrong select nack", a, 0);
      bus_stop();
   endtask

   task automatic t_array_write();
      logic a;
      bus_start();
      send_byte(8'hD4, a); check("R2 matching address ack", a, 1);
      send_byte(8'h00, a); check("R3 high address ack", a, 1);
      send_byte(8'h10, a); check("R3 low address ack", a, 1);
      send_byte(8'hA1, a); check("R4 data0 ack", a, 1);
      send_byte(8'hB2, a); check("R4 data1 ack", a, 1);
      send_byte(8'hC3, a); check("R4 data2 ack", a, 1);
      bus_stop();
      wq();
      check("R1 released after stop", sda_oe, 0);
      check("R4 mem10", mem[8'h10], 8'hA1);
      check("R4 mem11", mem[8'h11], 8'hB2);
      check("R4 mem12", mem[8'h12], 8'hC3);
   endtask

   task automatic t_locked();
      logic a;
      permit = 1'b0;
      bus_start();
      send_byte(8'hD4, a); check("R5 address ack while locked", a, 1);
      send_byte(8'h00, a); check("R5 high address ack while locked", a, 1);
      send_byte(8'h20, a); check("R3 low address ack while locked", a, 1);
      send_byte(8'h77, a); check("R5 data0 nack", a, 0);
      send_byte(8'h88, a); check("R5 data1 nack", a, 0);
      bus_stop();
      wq();
      check("R5 mem20 unchanged", mem[8'h20], 8'h20 ^ 8'h5A);
      check("R5 mem21 unchanged", mem[8'h21], 8'h21 ^ 8'h5A);
      permit = 1'b1;
   endtask

   task automatic t_register();
      logic a;
      bus_start();
      send_byte(8'hD4, a); check("R6 address ack", a, 1);
      send_byte(8'hFF, a); check("R6 high address ack", a, 1);
      send_byte(8'hC4, a); check("R6 low address ack", a, 1);
      send_byte(8'h11, a); check("R6 first register byte ack", a, 1);
      send_byte(8'h22, a); check("R6 second register byte nack", a, 0);
      send_byte(8'h33, a); check("R6 third register byte nack", a, 0);
      bus_stop();
      wq();
      check("R6 register written", mem[8'hC4], 8'h11);
      check("R6 next register untouched", mem[8'hC5], 8'hC5 ^ 8'h5A);
   endtask

   task automatic t_read();
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(8'hD4, a);
      send_byte(8'h00, a);
      send_byte(8'h10, a); check("R3 read setup address ack", a, 1);
      bus_start();
      send_byte(8'hD5, a); check("R7 read address ack", a, 1);
      recv_byte(1'b1, d); check("R7 read byte0", d, 8'hA1);
      recv_byte(1'b1, d); check("R8 read byte1 after ack", d, 8'hB2);
      recv_byte(1'b0, d); check("R8 read byte2", d, 8'hC3);
      recv_byte(1'b0, d); check("R8 released after nack", d, 8'hFF);
      bus_stop();
   endtask

   task automatic t_busy();
      logic a;
      busy = 1'b1;
      wq();
      bus_start();
      send_byte(8'hD4, a); check("R9 busy address nack", a, 0);
      send_byte(8'h00, a); check("R9 busy high address nack", a, 0);
      send_byte(8'h30, a);
      send_byte(8'h99, a); check("R9 busy data nack", a, 0);
      bus_stop();
      wq();
      check("R9 busy no write", mem[8'h30], 8'h30 ^ 8'h5A);
      busy = 1'b0;
      wq();
      bus_start();
      send_byte(8'hD4, a); check("R9 responds after busy", a, 1);
      bus_stop();
   endtask

   task automatic t_restart();
      logic a;
      bus_start();
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      send_byte(8'hD4, a); check("R1 address after mid-byte start", a, 1);
      send_byte(8'h00, a);
      send_byte(8'h40, a);
      send_byte(8'h5E, a); check("R1 data after restart ack", a, 1);
      bus_stop();
      wq();
      check("R1 data written after restart", mem[8'h40], 8'h5E);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_mismatch();
      t_array_write();
      t_locked();
      t_register();
      t_read();
      t_busy();
      t_restart();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule